// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the write-cycle command engine of a byte-wide parallel NOR flash that uses a status-register command set. A host issues commands as ordinary bus writes. Some commands take one cycle. Others take a second cycle, such as a confirm code, a data byte or a word count. The sequencer tracks which command is open and how far its sequence has progressed. It drives a small byte-addressed storage array, which the block writes and block-erases. It also keeps an 8-bit sticky status register. In that register bit 7 means ready, bit 5 means erase error and bit 4 means program error.

A registered read formatter answers bus reads according to the current state. It returns one of four things: array contents, the status byte, identification bytes or query data. Real program and erase timing is not modelled, so every operation completes in the cycle its last write arrives. The `wr_protect` input marks the part as read-only. While it is high, storage is left untouched and the error bits are raised.

The sequencer has ten states:
- `ST_ARRAY`: array read.
- `ST_STATUS`: status read.
- `ST_IDENT`: identification read.
- `ST_PROG`: a single program is armed.
- `ST_ERASE_CFM`: waiting for the erase confirm.
- `ST_LOCK_CFM`: waiting for the lock second cycle.
- `ST_QUERY`: query read.
- `ST_BUF_CNT`: waiting for the buffered-write count.
- `ST_BUF_DATA`: taking buffered-write data.
- `ST_BUF_CFM`: waiting for the buffered-write confirm.

The three read states `ST_ARRAY`, `ST_STATUS` and `ST_IDENT` decode the next write as a new command. Every completed operation lands in `ST_STATUS`. Every abort or unknown code lands in `ST_ARRAY`.

Top module: `nor_flash_seq`

## Requirements
- R1: After reset the sequencer is in array-read mode, the status register is 0x00 and every storage byte reads 0x00.
- R2: In a command-decoding state, a write of 0xFF, 0xF0, 0x00 or any unlisted code selects array-read mode.
- R3: A write of 0x40 or 0x10 arms a program. The next write stores its data byte at its address and sets status bit 7. The block then reads status.
- R4: While wr_protect is high, program and buffered-data writes leave storage unchanged and set status bits 4 and 7. An erase leaves storage unchanged and sets bits 5 and 7.
- R5: A write of 0x20 at once fills every byte of the block selected by the upper address bits (address / BLK_BYTES) with 0xFF and sets bit 7. The next write then decides the outcome: 0xD0 sets bit 7 and selects status read, and any other value selects array read.
- R6: A write of 0x50 clears all eight status bits and selects array read.
- R7: A write of 0x60 followed by 0xD0 or 0x01 sets bit 7 and selects status read. Any other second value selects array read. No lock sequence alters storage.
- R8: A write of 0x70 selects status read, which returns the status byte at any address. A write of 0x90 selects identification read: address 0 returns MFR_ID, address 1 returns DEV_ID, and other addresses return 0x00. Both modes decode the very next write as a new command.
- R9: A write of 0x98 selects query read. Address 0x10 returns 0x51, 0x11 returns 0x52, 0x12 returns 0x59, 0x13 returns 0x01, 0x27 returns log2 of the array size and 0x2C returns 0x01. All other addresses return 0x00. Writes other than 0xFF stay in query mode, and 0xFF selects array read.
- R10: A write of 0xE8 sets bit 7 and starts a buffered write. The next write gives a count N as a full byte. The following N+1 writes each store their byte at their own address. A final 0xD0 sets bit 7 and selects status read, and any other final value selects array read.
- R11: Status bits 7, 5 and 4 are sticky. Only the 0x50 command clears them.
- R12: bus_rdata changes only on a clock edge at which bus_re is high. It then holds the value selected by the state and address seen at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (6) | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data or command code |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data appears the next cycle |
| wr_protect | input | 1 | Part is read-only |
| bus_rdata | output | 8 | Registered read data |

## Verification
A wrong internal state surfaces on the first read that follows the faulty write. A sequencer stuck in a multi-cycle state returns the status byte where array data was expected. A lost ready or error bit shows as a wrong value the next time status is read. A misdirected erase or program stays hidden until the affected byte is read back in array mode. For that reason the bench reads after every operation and dumps the whole array at the end.

// File: rtl/nor_flash_pkg.sv
`timescale 1ns/1ps
package nor_flash_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY, ST_STATUS, ST_IDENT, ST_PROG, ST_ERASE_CFM,
        ST_LOCK_CFM, ST_QUERY, ST_BUF_CNT, ST_BUF_DATA, ST_BUF_CFM
    } seq_state_e;

    typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT, RD_QUERY} rd_sel_e;

    localparam logic [7:0] OP_RESET0  = 8'h00;
    localparam logic [7:0] OP_RESETF0 = 8'hF0;
    localparam logic [7:0] OP_RESETFF = 8'hFF;
    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_CLRSTS  = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_RDSTS   = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_BUFWR   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_LOCKALT = 8'h01;

    localparam int SB_READY = 7;
    localparam int SB_ERS_ERR = 5;
    localparam int SB_PRG_ERR = 4;

    function automatic logic cmd_state(seq_state_e s);
        return (s == ST_ARRAY) || (s == ST_STATUS) || (s == ST_IDENT);
    endfunction

endpackage

// File: rtl/nor_byte_store.sv
`timescale 1ns/1ps
module nor_byte_store #(
    parameter int BLK_BYTES = 16,
    parameter int BLK_CNT   = 4,
    localparam int DEPTH = BLK_BYTES * BLK_CNT,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(BLK_CNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          ers_en,
    input  logic [BW-1:0] ers_blk,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [DEPTH*8-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int BI = g / BLK_BYTES;
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= 8'h00;
            end else if (ers_en && ers_blk == BW'(BI)) begin
                cell_q <= 8'hFF;
            end else if (wr_en && wr_addr == AW'(g)) begin
                cell_q <= wr_data;
            end
        end
        assign flat[g*8 +: 8] = cell_q;
    end

    assign rd_data = flat[rd_addr*8 +: 8];
endmodule

// File: rtl/nor_cmd_fsm.sv
`timescale 1ns/1ps
module nor_cmd_fsm
    import nor_flash_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_protect,
    output seq_state_e state_o,
    output logic [7:0] status_o,
    output logic       st_we,
    output logic       st_ers
);
    seq_state_e state_q, state_d;
    logic [7:0] status_q, status_d;
    logic [7:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ARRAY;
            status_q <= 8'h00;
            cnt_q    <= 8'h00;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            cnt_q    <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        cnt_d    = cnt_q;
        if (wr_en) begin
            unique case (state_q)
                ST_ARRAY, ST_STATUS, ST_IDENT: begin
                    case (wr_data)
                        OP_PROG_A, OP_PROG_B: state_d = ST_PROG;
                        OP_ERASE: begin
                            status_d[SB_READY] = 1'b1;
                            if (wr_protect) status_d[SB_ERS_ERR] = 1'b1;
                            state_d = ST_ERASE_CFM;
                        end
                        OP_CLRSTS: begin
                            status_d = 8'h00;
                            state_d  = ST_ARRAY;
                        end
                        OP_LOCK:  state_d = ST_LOCK_CFM;
                        OP_RDSTS: state_d = ST_STATUS;
                        OP_IDENT: state_d = ST_IDENT;
                        OP_QUERY: state_d = ST_QUERY;
                        OP_BUFWR: begin
                            status_d[SB_READY] = 1'b1;
                            state_d = ST_BUF_CNT;
                        end
                        default:  state_d = ST_ARRAY;
                    endcase
                end
                ST_PROG: begin
                    status_d[SB_READY] = 1'b1;
                    if (wr_protect) status_d[SB_PRG_ERR] = 1'b1;
                    state_d = ST_STATUS;
                end
                ST_ERASE_CFM, ST_BUF_CFM: begin
                    if (wr_data == OP_CONFIRM) begin
                        status_d[SB_READY] = 1'b1;
                        state_d = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                ST_LOCK_CFM: begin
                    if (wr_data == OP_CONFIRM || wr_data == OP_LOCKALT) begin
                        status_d[SB_READY] = 1'b1;
                        state_d = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                ST_QUERY: begin
                    if (wr_data == OP_RESETFF) state_d = ST_ARRAY;
                end
                ST_BUF_CNT: begin
                    cnt_d   = wr_data;
                    state_d = ST_BUF_DATA;
                end
                ST_BUF_DATA: begin
                    status_d[SB_READY] = 1'b1;
                    if (wr_protect) status_d[SB_PRG_ERR] = 1'b1;
                    if (cnt_q == 8'h00) state_d = ST_BUF_CFM;
                    else cnt_d = cnt_q - 8'h01;
                end
            endcase
        end
    end

    always_comb begin
        st_we  = 1'b0;
        st_ers = 1'b0;
        if (wr_en && !wr_protect) begin
            st_we  = (state_q == ST_PROG) || (state_q == ST_BUF_DATA);
            st_ers = cmd_state(state_q) && (wr_data == OP_ERASE);
        end
    end

    assign state_o  = state_q;
    assign status_o = status_q;
endmodule

// File: rtl/nor_read_fmt.sv
`timescale 1ns/1ps
module nor_read_fmt
    import nor_flash_pkg::*;
#(
    parameter int         AW        = 6,
    parameter logic [7:0] MFR_ID    = 8'h89,
    parameter logic [7:0] DEV_ID    = 8'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  seq_state_e    state,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    arr_data,
    input  logic [7:0]    status,
    output logic [7:0]    rdata_o
);
    rd_sel_e    sel;
    logic [7:0] qa, ident_b, query_b, rd_d;

    always_comb begin
        unique case (state)
            ST_ARRAY: sel = RD_ARRAY;
            ST_IDENT: sel = RD_IDENT;
            ST_QUERY: sel = RD_QUERY;
            default:  sel = RD_STATUS;
        endcase
    end

    assign qa = 8'(addr);

    always_comb begin
        case (qa)
            8'h00:   ident_b = MFR_ID;
            8'h01:   ident_b = DEV_ID;
            default: ident_b = 8'h00;
        endcase
        case (qa)
            8'h10:   query_b = 8'h51;
            8'h11:   query_b = 8'h52;
            8'h12:   query_b = 8'h59;
            8'h13:   query_b = 8'h01;
            8'h27:   query_b = 8'(AW);
            8'h2C:   query_b = 8'h01;
            default: query_b = 8'h00;
        endcase
        unique case (sel)
            RD_ARRAY:  rd_d = arr_data;
            RD_STATUS: rd_d = status;
            RD_IDENT:  rd_d = ident_b;
            RD_QUERY:  rd_d = query_b;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_o <= 8'h00;
        else if (rd_en) rdata_o <= rd_d;
    end
endmodule

// File: rtl/nor_flash_seq.sv
`timescale 1ns/1ps
module nor_flash_seq
    import nor_flash_pkg::*;
#(
    parameter int         BLK_BYTES = 16,
    parameter int         BLK_CNT   = 4,
    parameter logic [7:0] MFR_ID    = 8'h89,
    parameter logic [7:0] DEV_ID    = 8'h18,
    localparam int DEPTH = BLK_BYTES * BLK_CNT,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(BLK_CNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic          wr_protect,
    output logic [7:0]    bus_rdata
);
    seq_state_e state_w;
    logic [7:0] status_w, arr_w;
    logic       we_w, ers_w;

    nor_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_data(bus_wdata),
        .wr_protect(wr_protect), .state_o(state_w), .status_o(status_w),
        .st_we(we_w), .st_ers(ers_w)
    );

    nor_byte_store #(.BLK_BYTES(BLK_BYTES), .BLK_CNT(BLK_CNT)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(we_w), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .ers_en(ers_w), .ers_blk(bus_addr[AW-1 -: BW]),
        .rd_addr(bus_addr), .rd_data(arr_w)
    );

    nor_read_fmt #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_fmt (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_re), .state(state_w),
        .addr(bus_addr), .arr_data(arr_w), .status(status_w),
        .rdata_o(bus_rdata)
    );
endmodule

// File: rtl/nor_flash_seq_chk.sv
`timescale 1ns/1ps
module nor_flash_seq_chk
    import nor_flash_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       we,
    input logic [7:0] wdata,
    input logic       wr_protect,
    input seq_state_e state,
    input logic [7:0] status
);
    // R3
    prog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && state == ST_PROG) |=> (status[7] && state == ST_STATUS));

    // R4
    ro_prog_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_protect && (state == ST_PROG || state == ST_BUF_DATA)) |=> status[4]);

    // R5
    erase_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cmd_state(state) && wdata == 8'h20) |=> (state == ST_ERASE_CFM && status[7]));

    // R6
    clr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cmd_state(state) && wdata == 8'h50) |=> (status == 8'h00 && state == ST_ARRAY));

    // R11
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !(we && cmd_state(state) && wdata == 8'h50)) |=> status[7]);

    // R8
    status_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cmd_state(state) && wdata == 8'h70) |=> state == ST_STATUS);
endmodule

bind nor_flash_seq nor_flash_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .wdata(bus_wdata),
    .wr_protect(wr_protect), .state(state_w), .status(status_w)
);

// File: tb/nor_flash_seq_tb_top.sv
`timescale 1ns/1ps
module nor_flash_seq_tb_top;
    localparam int DEPTH = 64;
    localparam int BLKB  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0, re = 1'b0, wp = 1'b0;
    logic [7:0] rdata;

    always #10 clk = ~clk;

    nor_flash_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_re(re), .wr_protect(wp), .bus_rdata(rdata)
    );

    // model: 0 array,1 status,2 ident,3 prog,4 erase cfm,5 lock,6 query,7 bcnt,8 bdata,9 bcfm
    logic [7:0] mm [DEPTH];
    logic [7:0] mst;
    int mmode, mcnt;
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] q_exp(int a);
        case (a)
            'h10: return 8'h51;
            'h11: return 8'h52;
            'h12: return 8'h59;
            'h13: return 8'h01;
            'h27: return 8'd6;
            'h2C: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(int a);
        case (mmode)
            0: return mm[a];
            2: return (a == 0) ? 8'h89 : (a == 1) ? 8'h18 : 8'h00;
            6: return q_exp(a);
            default: return mst;
        endcase
    endfunction

    task automatic model_wr(int a, int d);
        case (mmode)
            0, 1, 2: begin
                case (d)
                    'h10, 'h40: mmode = 3;
                    'h20: begin
                        if (!wp) for (int i = 0; i < BLKB; i++) mm[(a / BLKB) * BLKB + i] = 8'hFF;
                        mst = mst | 8'h80 | (wp ? 8'h20 : 8'h00);
                        mmode = 4;
                    end
                    'h50: begin mst = 8'h00; mmode = 0; end
                    'h60: mmode = 5;
                    'h70: mmode = 1;
                    'h90: mmode = 2;
                    'h98: mmode = 6;
                    'hE8: begin mst = mst | 8'h80; mmode = 7; end
                    default: mmode = 0;
                endcase
            end
            3: begin
                if (!wp) mm[a] = 8'(d);
                mst = mst | 8'h80 | (wp ? 8'h10 : 8'h00);
                mmode = 1;
            end
            4, 9: begin
                if (d == 'hD0) begin mst = mst | 8'h80; mmode = 1; end
                else mmode = 0;
            end
            5: begin
                if (d == 'hD0 || d == 'h01) begin mst = mst | 8'h80; mmode = 1; end
                else mmode = 0;
            end
            6: if (d == 'hFF) mmode = 0;
            7: begin mcnt = d; mmode = 8; end
            8: begin
                if (!wp) mm[a] = 8'(d);
                mst = mst | 8'h80 | (wp ? 8'h10 : 8'h00);
                if (mcnt == 0) mmode = 9;
                else mcnt = mcnt - 1;
            end
            default: mmode = 0;
        endcase
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        addr = 6'(a); wdata = 8'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(int a, output logic [7:0] v);
        @(negedge clk);
        addr = 6'(a); re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        v = rdata;
    endtask

    task automatic rdchk(string tag, int a);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp_rd(a));
    endtask

    task automatic to_array();
        for (int k = 0; k < 400 && mmode != 0; k++) wr(0, 'hFF);
    endtask

    task automatic dump(string tag);
        to_array();
        for (int a = 0; a < DEPTH; a++) rdchk(tag, a);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL WATCHDOG run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int unsigned seed = 32'h00C0FFEE;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) mm[i] = 8'h00;
        mst = 8'h00; mmode = 0; mcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3, v); chk("R1 array", v, 8'h00);
        wr(0, 'h70); rd(9, v); chk("R1 status", v, 8'h00);

        // R3 program, both opcodes
        wr(0, 'h40); wr(5, 'hA5); rd(0, v); chk("R3 ready", v, 8'h80);
        wr(0, 'hFF); rd(5, v); chk("R3 data", v, 8'hA5);
        wr(0, 'h10); wr(7, 'h3C); wr(0, 'hFF); rd(7, v); chk("R3 alt", v, 8'h3C);

        // R6 clear status
        wr(0, 'h50); rd(5, v); chk("R6 array", v, 8'hA5);
        wr(0, 'h70); rd(0, v); chk("R6 cleared", v, 8'h00);

        // R5 erase block 1 with confirm
        wr(0, 'h40); wr('h1F, 'h11); wr(0, 'hFF);
        wr('h13, 'h20); rd(0, v); chk("R5 armed", v, 8'h80);
        wr(0, 'hD0); rd(0, v); chk("R5 confirm", v, 8'h80);
        wr(0, 'hFF);
        rd('h10, v); chk("R5 lo", v, 8'hFF);
        rd('h1F, v); chk("R5 hi", v, 8'hFF);
        rd('h0F, v); chk("R5 below", v, 8'h00);
        rd('h20, v); chk("R5 above", v, 8'h00);
        wr('h25, 'h20); wr(0, 'h33); rd('h21, v); chk("R5 bad confirm array", v, 8'hFF);

        // R7 lock
        wr(0, 'h50); wr(0, 'h60); wr(0, 'h01); rd(4, v); chk("R7 lock 01", v, 8'h80);
        wr(0, 'h60); wr(0, 'h77); rd(5, v); chk("R7 bad second", v, 8'hA5);

        // R8 ident, then next write decoded as command
        wr(0, 'h90);
        rd(0, v); chk("R8 mfr", v, 8'h89);
        rd(1, v); chk("R8 dev", v, 8'h18);
        rd(2, v); chk("R8 other", v, 8'h00);
        wr(0, 'h40); wr(8, 'h5A); wr(0, 'hFF); rd(8, v); chk("R8 next cmd", v, 8'h5A);

        // R9 query
        wr(0, 'h98);
        rd('h10, v); chk("R9 Q", v, 8'h51);
        rd('h11, v); chk("R9 R", v, 8'h52);
        rd('h12, v); chk("R9 Y", v, 8'h59);
        rd('h27, v); chk("R9 size", v, 8'd6);
        wr(0, 'h00); rd('h10, v); chk("R9 stays", v, 8'h51);
        wr(0, 'hFF); rd(5, v); chk("R9 exit", v, 8'hA5);

        // R10 buffered write, count 2 => three bytes
        wr(0, 'h50); wr(0, 'hE8); rd(0, v); chk("R10 ready", v, 8'h80);
        wr(0, 2); wr('h30, 'h01); wr('h31, 'h02); wr('h32, 'h03);
        wr(0, 'hD0); rd(0, v); chk("R10 confirm", v, 8'h80);
        wr(0, 'hFF);
        rd('h30, v); chk("R10 b0", v, 8'h01);
        rd('h32, v); chk("R10 b2", v, 8'h03);
        rd('h33, v); chk("R10 past", v, 8'h00);
        wr(0, 'hE8); wr(0, 0); wr('h34, 'h44); wr(0, 'h00);
        rd('h34, v); chk("R10 abort array", v, 8'h44);

        // R4 read-only part
        wp = 1'b1;
        wr(0, 'h50); wr(0, 'h40); wr(6, 'h11); rd(0, v); chk("R4 prog flag", v, 8'h90);
        wr(0, 'h20); wr(0, 'hD0); rd(0, v); chk("R4 erase flag", v, 8'hB0);
        wr(0, 'hFF); rd(6, v); chk("R4 no prog", v, 8'h00);
        rd(5, v); chk("R4 no erase", v, 8'hA5);
        // R11 sticky through other commands
        wr(0, 'h70); wr(0, 'h60); wr(0, 'hD0); rd(0, v); chk("R11 sticky", v, 8'hB0);
        wp = 1'b0;

        // R2 resets and unknown codes
        wr(0, 'h70); wr(0, 'h37); rd(5, v); chk("R2 unknown", v, 8'hA5);
        wr(0, 'h70); wr(0, 'hF0); rd(5, v); chk("R2 F0", v, 8'hA5);
        wr(0, 'h90); wr(0, 'h00); rd(5, v); chk("R2 00", v, 8'hA5);

        // R12 hold while bus_re low
        rd(5, v);
        @(negedge clk); addr = 6'd7; @(negedge clk);
        chk("R12 hold", rdata, 8'hA5);

        // random phase
        for (int n = 0; n < 400; n++) begin
            int op, a;
            op = int'($urandom_range(0, 11));
            a  = int'($urandom_range(0, DEPTH - 1));
            if ($urandom_range(0, 9) == 0) begin @(negedge clk); wp = ~wp; end
            case (op)
                0: begin wr(0, ($urandom_range(0, 1) != 0) ? 'h40 : 'h10); wr(a, int'($urandom_range(0, 255))); end
                1: begin wr(a, 'h20); wr(0, ($urandom_range(0, 2) == 0) ? 'h5 : 'hD0); end
                2: wr(0, 'h50);
                3: begin wr(0, 'h60); wr(0, ($urandom_range(0, 2) == 0) ? 'h01 : 'hD0); end
                4: wr(0, 'h70);
                5: wr(0, 'h90);
                6: wr(0, 'h98);
                7: begin
                    int c;
                    c = int'($urandom_range(0, 3));
                    wr(0, 'hE8); wr(0, c);
                    for (int j = 0; j <= c; j++) wr((a + j) % DEPTH, int'($urandom_range(0, 255)));
                    wr(0, ($urandom_range(0, 3) == 0) ? 'h00 : 'hD0);
                end
                8: wr(0, ($urandom_range(0, 1) != 0) ? 'hFF : 'hF0);
                default: wr(a, int'($urandom_range(0, 255)));
            endcase
            rdchk("R2-R11 random read", int'($urandom_range(0, DEPTH - 1)));
        end
        wp = 1'b0;
        dump("R5 R10 final array");

        done = 1;
        summary();
        $finish;
    end
endmodule